// File: doc/BRIEF.md
# Dual-Port Pixel Output Demultiplexer

This block accepts one pixel data byte per clock, qualified by an input valid, together with a one-cycle horizontal sync marker. It distributes the bytes over two output ports, A and B. In single-channel operation every byte is sent to port A. In dual-channel operation the bytes of a line are split into pairs. In interleaved presentation, consecutive bytes land on alternate ports one clock apart. In parallel presentation, the two bytes of a pair appear on both ports on the same clock.

Each port has its own valid strobe. An output data clock is also produced. A phase bit selects which port takes the first byte after the sync marker.

The three control bits come from a mode byte that is sampled only in the sync cycle. A change in mode therefore never splits a line in a mixed way. The pair alternation restarts at every sync, so a line with an odd byte count does not shift the next line. A slot sequencer with three named states tracks the pair alternation:

- `ST_IDLE`: a line has started and no byte has arrived yet.
- `ST_FIRST`: the next byte is the even, first-of-pair byte.
- `ST_SECOND`: the next byte is the odd, second-of-pair byte.

The transitions are as follows:

- A sync with no byte in the same cycle leads to `ST_IDLE`.
- A byte in the first slot, in dual mode, leads to `ST_SECOND`.
- A byte in the first slot, in single mode, leads to `ST_FIRST`.
- A byte in `ST_SECOND` leads to `ST_FIRST`.
- A cycle with no byte and no sync keeps the current state.

Top module: `pixel_port_splitter`

## Requirements
- R1: After reset both port data outputs, both valid strobes and the data clock are 0. The active configuration is dual-channel, parallel, and port B first.
- R2: The mode input bit 7 selects dual channel (1) or single channel (0). Bit 6 selects parallel (1) or interleaved (0). Bit 5 selects port A first (1) or port B first (0). The other bits are ignored. The byte is captured only in a cycle with the sync marker high, and it already applies to a byte that arrives in that same cycle.
- R3: In single-channel mode every accepted byte appears on port A one clock later, with the port A valid high for that clock only. The port B valid stays low.
- R4: In interleaved dual mode, byte k of a line is counted from 0. The first byte is the one in the sync cycle, or the first one after it. Byte k goes to the first port when k is even and to the other port when k is odd. It appears one clock later, with only that port's valid high.
- R5: In parallel dual mode an even byte is held internally and produces no strobe. One clock after the following odd byte, the first port shows the even byte and the other port shows the odd byte, and both valids are high for that clock.
- R6: The first port is A when the captured phase bit is 1, and B when it is 0.
- R7: A sync marker restarts the count at byte 0. In parallel mode, an unpaired even byte that is still held at that point is discarded and never presented.
- R8: Changes on the mode input in cycles without the sync marker have no effect on routing.
- R9: The data clock output behaves as follows. In single mode it is 1 for the clock after each accepted byte and 0 otherwise. In dual mode, after an accepted byte it is 1 if the byte was even and 0 if it was odd, and it holds its value in cycles without a byte.
- R10: A port whose valid is low keeps its previous data value.
- R11: Cycles with the input valid low neither advance the byte count nor produce strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte qualifier |
| in_data | input | DATA_W | Input pixel byte |
| hsync | input | 1 | One-cycle line start marker |
| mode_i | input | 8 | Mode byte (bits 7, 6 and 5 used) |
| porta_data | output | DATA_W | Port A data |
| portb_data | output | DATA_W | Port B data |
| porta_vld | output | 1 | Port A update strobe |
| portb_vld | output | 1 | Port B update strobe |
| dclk_o | output | 1 | Output data clock |

## Verification
The bench builds the block with DATA_W = 6. A running byte counter then wraps within a few lines, and every mode byte value in the upper three bits can be swept together with line lengths from 1 to 5. This covers both parities of line length, both placements of the first byte (in the sync cycle or after it), and unpaired trailing bytes in every one of the eight configurations. Dedicated passes add input gaps, mode changes in the middle of a line, and the behaviour from reset before any sync has arrived.

// File: rtl/pps_pkg.sv
package pps_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FIRST  = 2'd1,
        ST_SECOND = 2'd2
    } slot_e;

    typedef struct packed {
        logic dual;
        logic par;
        logic phase_a;
    } cfg_t;

    localparam cfg_t CFG_RST = '{dual: 1'b1, par: 1'b1, phase_a: 1'b0};

endpackage

// File: rtl/pps_cfg.sv
module pps_cfg
    import pps_pkg::*;
#(
    parameter int CHAN_BIT = 7,
    parameter int OUT_BIT  = 6,
    parameter int PH_BIT   = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hsync,
    input  logic [7:0] mode_i,
    output cfg_t       cfg_now,
    output cfg_t       cfg_q
);
    cfg_t decoded;

    always_comb begin
        decoded.dual    = mode_i[CHAN_BIT];
        decoded.par     = mode_i[OUT_BIT];
        decoded.phase_a = mode_i[PH_BIT];
    end

    // R2 / R8: the sync cycle alone loads the mode; it governs its own cycle too
    assign cfg_now = hsync ? decoded : cfg_q;

    always_ff @(posedge clk) begin
        if (!rst_n)     cfg_q <= CFG_RST;
        else if (hsync) cfg_q <= decoded;
    end
endmodule

// File: rtl/pps_slot_fsm.sv
module pps_slot_fsm
    import pps_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  hsync,
    input  logic  in_valid,
    input  logic  dual,
    output logic  first_slot,
    output slot_e state_o
);
    slot_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (hsync) begin
            // R7: line restart
            if (in_valid) state_d = dual ? ST_SECOND : ST_FIRST;
            else          state_d = ST_IDLE;
        end else if (in_valid) begin
            unique case (state_q)
                ST_IDLE, ST_FIRST: state_d = dual ? ST_SECOND : ST_FIRST;
                ST_SECOND:         state_d = ST_FIRST;
                default:           state_d = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        first_slot = hsync || (state_q != ST_SECOND);
        state_o    = state_q;
    end
endmodule

// File: rtl/pps_router.sv
module pps_router
    import pps_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              first_slot,
    input  cfg_t              cfg_now,
    output logic [DATA_W-1:0] porta_data,
    output logic [DATA_W-1:0] portb_data,
    output logic              porta_vld,
    output logic              portb_vld,
    output logic              dclk_o
);
    localparam int NPORT = 2;

    logic [DATA_W-1:0] hold_q;
    logic              hold_we;
    logic [NPORT-1:0]  wr;
    logic [DATA_W-1:0] nd   [NPORT];
    logic [DATA_W-1:0] pdat [NPORT];
    logic [NPORT-1:0]  pvld;
    logic              to_a;

    always_comb begin
        wr      = '0;
        hold_we = 1'b0;
        nd[0]   = in_data;
        nd[1]   = in_data;
        to_a    = (first_slot == cfg_now.phase_a);
        if (in_valid) begin
            if (!cfg_now.dual) begin
                wr[0] = 1'b1;                          // R3
            end else if (!cfg_now.par) begin
                wr[0] = to_a;                          // R4 R6
                wr[1] = !to_a;
            end else if (first_slot) begin
                hold_we = 1'b1;                        // R5
            end else begin
                wr    = 2'b11;
                nd[0] = cfg_now.phase_a ? hold_q  : in_data;
                nd[1] = cfg_now.phase_a ? in_data : hold_q;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       hold_q <= '0;
        else if (hold_we) hold_q <= in_data;
    end

    for (genvar g = 0; g < NPORT; g++) begin : g_port
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pdat[g] <= '0;
                pvld[g] <= 1'b0;
            end else begin
                pvld[g] <= wr[g];
                if (wr[g]) pdat[g] <= nd[g];           // R10
            end
        end
    end

    // R9: output data clock
    always_ff @(posedge clk) begin
        if (!rst_n)              dclk_o <= 1'b0;
        else if (!cfg_now.dual)  dclk_o <= in_valid;
        else if (in_valid)       dclk_o <= first_slot;
    end

    assign porta_data = pdat[0];
    assign portb_data = pdat[1];
    assign porta_vld  = pvld[0];
    assign portb_vld  = pvld[1];
endmodule

// File: rtl/pixel_port_splitter.sv
module pixel_port_splitter
    import pps_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int CHAN_BIT = 7,
    parameter int OUT_BIT  = 6,
    parameter int PH_BIT   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              hsync,
    input  logic [7:0]        mode_i,
    output logic [DATA_W-1:0] porta_data,
    output logic [DATA_W-1:0] portb_data,
    output logic              porta_vld,
    output logic              portb_vld,
    output logic              dclk_o
);
    cfg_t  cfg_now;
    cfg_t  cfg_q;
    logic  first_slot;
    slot_e slot_state;

    pps_cfg #(.CHAN_BIT(CHAN_BIT), .OUT_BIT(OUT_BIT), .PH_BIT(PH_BIT)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .hsync   (hsync),
        .mode_i  (mode_i),
        .cfg_now (cfg_now),
        .cfg_q   (cfg_q)
    );

    pps_slot_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .hsync      (hsync),
        .in_valid   (in_valid),
        .dual       (cfg_now.dual),
        .first_slot (first_slot),
        .state_o    (slot_state)
    );

    pps_router #(.DATA_W(DATA_W)) u_router (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .first_slot (first_slot),
        .cfg_now    (cfg_now),
        .porta_data (porta_data),
        .portb_data (portb_data),
        .porta_vld  (porta_vld),
        .portb_vld  (portb_vld),
        .dclk_o     (dclk_o)
    );
endmodule

// File: rtl/pps_checker.sv
module pps_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              porta_vld,
    input logic              portb_vld,
    input logic [DATA_W-1:0] porta_data,
    input logic [DATA_W-1:0] portb_data,
    input logic              cfg_dual,
    input logic              cfg_par
);
    a_r3_b_quiet_single: assert property (@(posedge clk) disable iff (!rst_n)
        portb_vld |-> cfg_dual);

    a_r4_single_strobe_interleaved: assert property (@(posedge clk) disable iff (!rst_n)
        (porta_vld && portb_vld) |-> cfg_par);

    a_r5_pair_not_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
        (porta_vld && portb_vld) |=> !(porta_vld && portb_vld));

    a_r11_strobe_needs_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (porta_vld || portb_vld) |-> $past(in_valid));

    a_r10_a_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !porta_vld |-> $stable(porta_data));

    a_r10_b_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !portb_vld |-> $stable(portb_data));
endmodule

bind pixel_port_splitter pps_checker #(.DATA_W(DATA_W)) u_pps_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .porta_vld  (porta_vld),
    .portb_vld  (portb_vld),
    .porta_data (porta_data),
    .portb_data (portb_data),
    .cfg_dual   (cfg_q.dual),
    .cfg_par    (cfg_q.par)
);

// File: tb/test_pixel_port_splitter.sv
module test_pixel_port_splitter;
    localparam int DW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic          hsync = 1'b0;
    logic [7:0]    mode_i = 8'h00;
    logic [DW-1:0] porta_data, portb_data;
    logic          porta_vld, portb_vld, dclk_o;

    pixel_port_splitter #(.DATA_W(DW)) i_pixel_port_splitter (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .hsync(hsync), .mode_i(mode_i), .porta_data(porta_data),
        .portb_data(portb_data), .porta_vld(porta_vld),
        .portb_vld(portb_vld), .dclk_o(dclk_o)
    );

    always #4 clk = ~clk;   // 125 MHz

    int    n_chk = 0, n_fail = 0, cycles = 0;
    bit    done = 0;
    string tag = "R1";

    // bench model state, derived from the requirements
    bit            m_dual = 1, m_par = 1, m_ph = 0, m_odd = 0;
    logic [DW-1:0] m_hold = '0, e_a = '0, e_b = '0;
    bit            e_va = 0, e_vb = 0, e_clk = 0;
    logic [DW-1:0] dctr = '0;

    task automatic chk(input string what, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s got %0h exp %0h", tag, what, got, exp);
        end
    endtask

    task automatic check_all();
        chk("porta_data", porta_data, e_a);
        chk("portb_data", portb_data, e_b);
        chk("porta_vld",  porta_vld,  e_va);
        chk("portb_vld",  portb_vld,  e_vb);
        chk("dclk_o R9",  dclk_o,     e_clk);
    endtask

    task automatic model(input bit hs, input bit v, input logic [DW-1:0] d,
                         input logic [7:0] md);
        bit first;
        e_va = 0; e_vb = 0;
        if (hs) begin                    // R2 R7
            m_dual = md[7]; m_par = md[6]; m_ph = md[5]; m_odd = 0;
        end
        if (!m_dual) begin               // R3
            if (v) begin e_a = d; e_va = 1; end
            e_clk = v;
        end else if (v) begin
            first = !m_odd;
            e_clk = first;
            if (!m_par) begin            // R4 R6
                if (first == m_ph) begin e_a = d; e_va = 1; end
                else               begin e_b = d; e_vb = 1; end
            end else if (first) begin
                m_hold = d;              // R5
            end else begin
                e_a = m_ph ? m_hold : d;
                e_b = m_ph ? d : m_hold;
                e_va = 1; e_vb = 1;
            end
            m_odd = !m_odd;
        end
    endtask

    task automatic step(input bit hs, input bit v, input logic [7:0] md);
        logic [DW-1:0] d;
        d = dctr;
        if (v) dctr = dctr + 1'b1;
        hsync = hs; in_valid = v; in_data = d; mode_i = md;
        @(posedge clk);
        model(hs, v, d, md);
        @(negedge clk);
        check_all();
    endtask

    task automatic line(input logic [7:0] md, input int len, input bit on_sync,
                        input bit gaps);
        int left;
        left = len;
        step(1'b1, on_sync && (left > 0), md);
        if (on_sync && len > 0) left--;
        while (left > 0) begin
            if (gaps) step(1'b0, 1'b0, ~md);   // R11 R8
            step(1'b0, 1'b1, ~md);
            left--;
        end
        step(1'b0, 1'b0, ~md);
        step(1'b0, 1'b0, md);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        tag = "R1";
        check_all();
        rst_n = 1'b1;
        // R1: reset configuration is dual, parallel, port B first
        for (int i = 0; i < 5; i++) step(1'b0, 1'b1, 8'h1F);
        step(1'b0, 1'b0, 8'h00);

        // R2 R3 R4 R5 R6 R7: sweep the three mode bits and line lengths
        for (int m = 0; m < 8; m++) begin
            for (int len = 1; len <= 5; len++) begin
                for (int s = 0; s < 2; s++) begin
                    logic [7:0] md;
                    md = {m[2:0], 5'b10101};
                    if (!md[7])     tag = "R3 R2 R10";
                    else if (md[6]) tag = "R5 R6 R7";
                    else            tag = "R4 R6 R10";
                    line(md, len, s[0], 1'b0);
                end
            end
        end

        // R11 with R8: gaps and mode toggling mid-line
        for (int m = 0; m < 8; m++) begin
            tag = "R11 R8";
            line({m[2:0], 5'b00000}, 5, 1'b0, 1'b1);
        end

        // R7: odd parallel lines back to back, pending byte must vanish
        tag = "R7";
        for (int i = 0; i < 4; i++) line(8'hE0, 3, i[0], 1'b0);
        line(8'hC0, 1, 1'b1, 1'b0);
        line(8'hC0, 2, 1'b0, 1'b0);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog R1 got %0d exp %0d", cycles, 100000);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule